// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the digital core of a byte-wide serial EEPROM that answers as an SPI slave. It runs on one system clock that oversamples the serial pins. It decodes one-byte instructions, builds a 16-bit address and streams data in or out, most significant bit first. The storage is an on-chip RAM of `MEM_BYTES` bytes, 2048 by default or 1024 for the smaller variant. A programming cycle of `WRITE_CYCLES` clocks stands in for the self-timed erase/write.

A host reads by sending the read opcode and an address, then clocking out bytes for as long as chip select stays low. The address steps forward after every byte. To write, the host first sets the write-enable latch. It then sends the write opcode, an address and up to one page of data into a page buffer, and commits the page by raising chip select on a byte boundary. A status byte reports progress and holds two protection bits that fence off part of the array. A hold pin pauses the transfer, and a write-protect pin freezes the status register.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Both SPI clock polarities work: mode 0 (SCK idles low) and mode 3 (SCK idles high). SI is sampled on rising SCK edges, SO changes on falling SCK edges, and every byte is sent MSB first.
- R2: Opcodes are READ 0x03, WRITE 0x02, WREN 0x06, WRDI 0x04, RDSR 0x05 and WRSR 0x01. The status byte is {4'b0, protect[1:0], wel, wip}, with wip in bit 0, wel in bit 1 and the protect bits in bits 3:2. It reads 0x00 after reset.
- R3: READ takes a 16-bit address, high byte first. Address bits at and above log2(MEM_BYTES) are ignored. Data continues from successive addresses while CS stays low, and the address wraps from the last byte to 0.
- R4: The write-enable latch is 0 after reset. WREN sets it and WRDI clears it. WRITE and WRSR issued while the latch is 0 leave the array and the status unchanged.
- R5: WRITE data goes into a page buffer of PAGE_BYTES (16). Data bytes that run past the end of the page wrap to the start of the same page.
- R6: A WRITE or WRSR is committed only when CS rises with a whole number of bytes clocked in, and after at least one data byte. Otherwise nothing changes and the latch stays set.
- R7: A commit sets wip for WRITE_CYCLES clocks and clears the write-enable latch when it ends. While wip is set, every opcode except RDSR is ignored, and SO stays disabled for ignored opcodes.
- R8: The protect bits lock part of the array against writes: 00 locks nothing, 01 the top quarter, 10 the top half and 11 the whole array. A write into a locked page changes nothing, starts no cycle and leaves the latch set.
- R9: While WP is low, WRSR is ignored.
- R10: While HOLD is low, SCK and SI edges are ignored and SO is disabled. When HOLD returns high, the transfer resumes where it stopped.
- R11: CS high ends any transfer at once and disables SO. The next CS low starts at a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples SCK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Chip select, active low |
| hold_ni | input | 1 | Pause, active low |
| wp_ni | input | 1 | Status write protect, active low |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | SO drive enable (0 means high impedance) |

## Verification
Each pin passes through a two-flop synchronizer and an edge register. The block therefore acts three clocks after a pin changes. An SO bit is valid three clocks after the falling SCK edge, and the bench samples it four clocks after that edge, just before the next rising edge. A commit starts three clocks after CS rises and wip then holds for WRITE_CYCLES clocks. The bench does not count out that window: it reads the status byte, expects wip right after a commit, and then polls until wip clears before it checks the array or the write-enable latch. Locked writes and ignored opcodes are checked through RDSR and through read-back of the untouched addresses.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;

  typedef enum logic [2:0] {
    PH_OPC, PH_AHI, PH_ALO, PH_WDAT, PH_RDAT, PH_SRW, PH_SRR, PH_SKIP
  } phase_e;

  // top = two MSBs of the address (array quarter)
  function automatic logic region_locked(input logic [1:0] bp, input logic [1:0] top);
    case (bp)
      2'd0:    return 1'b0;
      2'd1:    return &top;
      2'd2:    return top[1];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [PW-1:0] widx_i,
  input  logic [7:0]    wdata_i,
  input  logic [PW-1:0] ridx_i,
  output logic [7:0]    rdata_o,
  output logic          rvalid_o
);
  logic [7:0]       data_q [DEPTH];
  logic [DEPTH-1:0] val_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (widx_i == PW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    val_q[g] <= 1'b0;
      else if (clr_i) val_q[g] <= 1'b0;
      else if (hit)   val_q[g] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit) data_q[g] <= wdata_i;
    end
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = val_q[ridx_i];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import eep_pkg::*;
#(
  parameter int MEM_BYTES    = 2048,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic cs_ni,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic so_o,
  output logic so_en_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WRITE_CYCLES) + 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(WRITE_CYCLES - 1);
  localparam logic [CW-1:0] PG_LIM   = CW'(PAGE_BYTES);

  // pin sync: {cs_n, hold_n, wp_n, sck, si}
  logic [4:0] pins_s;
  eep_sync #(.W(5), .RST_VAL(5'b11100)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, hold_ni, wp_ni, sck_i, si_i}),
    .q_o    (pins_s)
  );

  logic cs_s, hold_s, wp_s, sck_s, si_s;
  assign {cs_s, hold_s, wp_s, sck_s, si_s} = pins_s;

  logic sck_q, cs_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  logic cs_act, hold_act, rise, fall, cs_end;
  assign cs_act   = ~cs_s;
  assign hold_act = hold_s;
  assign rise     = cs_act & hold_act & sck_s & ~sck_q;
  assign fall     = cs_act & hold_act & ~sck_s & sck_q;
  assign cs_end   = cs_s & ~cs_q;

  phase_e        phase_q;
  logic [2:0]    bit_cnt_q;
  logic [6:0]    shift_q;
  logic [AW-1:0] addr_q;
  logic          is_wr_q, wel_q, data_seen_q, sr_seen_q, busy_q, prog_q;
  logic [1:0]    bp_q, sr_new_q;
  logic [CW-1:0] cyc_q;
  logic [7:0]    rx_byte, status, mem_rdata, lat_rdata;
  logic          byte_done, lat_valid, lat_clr, lat_we, mem_we, wr_ok;
  logic [AW-1:0] mem_waddr;

  assign rx_byte   = {shift_q, si_s};
  assign byte_done = rise && (bit_cnt_q == 3'd7);
  assign status    = {4'b0000, bp_q, wel_q, busy_q};

  assign wr_ok   = wel_q && !busy_q;
  assign lat_clr = byte_done && (phase_q == PH_OPC) && (rx_byte == OP_WRITE) && wr_ok;
  assign lat_we  = byte_done && (phase_q == PH_WDAT);

  eep_page_latch #(.DEPTH(PAGE_BYTES)) i_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (lat_clr),
    .we_i     (lat_we),
    .widx_i   (addr_q[PW-1:0]),
    .wdata_i  (rx_byte),
    .ridx_i   (cyc_q[PW-1:0]),
    .rdata_o  (lat_rdata),
    .rvalid_o (lat_valid)
  );

  assign mem_we    = prog_q && (cyc_q < PG_LIM) && lat_valid;
  assign mem_waddr = {addr_q[AW-1:PW], cyc_q[PW-1:0]};

  eep_ram #(.DEPTH(MEM_BYTES)) i_ram (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (lat_rdata),
    .raddr_i (addr_q),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_OPC;
      bit_cnt_q   <= '0;
      shift_q     <= '0;
      addr_q      <= '0;
      is_wr_q     <= 1'b0;
      wel_q       <= 1'b0;
      bp_q        <= '0;
      sr_new_q    <= '0;
      data_seen_q <= 1'b0;
      sr_seen_q   <= 1'b0;
      busy_q      <= 1'b0;
      prog_q      <= 1'b0;
      cyc_q       <= '0;
    end else begin
      if (busy_q) begin
        if (cyc_q == CYC_LAST) begin
          busy_q <= 1'b0;
          prog_q <= 1'b0;
          wel_q  <= 1'b0;
          cyc_q  <= '0;
        end else begin
          cyc_q <= cyc_q + 1'b1;
        end
      end

      if (!cs_act) begin
        phase_q     <= PH_OPC;
        bit_cnt_q   <= '0;
        data_seen_q <= 1'b0;
        sr_seen_q   <= 1'b0;
        // commit only on a byte boundary
        if (cs_end && bit_cnt_q == 3'd0 && !busy_q) begin
          if (phase_q == PH_WDAT && data_seen_q &&
              !region_locked(bp_q, addr_q[AW-1 -: 2])) begin
            busy_q <= 1'b1;
            prog_q <= 1'b1;
          end else if (phase_q == PH_SRW && sr_seen_q) begin
            busy_q <= 1'b1;
            bp_q   <= sr_new_q;
          end
        end
      end else if (rise) begin
        shift_q   <= rx_byte[6:0];
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == 3'd7) begin
          case (phase_q)
            PH_OPC: begin
              if (busy_q) begin
                phase_q <= (rx_byte == OP_RDSR) ? PH_SRR : PH_SKIP;
              end else begin
                phase_q <= PH_SKIP;
                case (rx_byte)
                  OP_READ:  begin phase_q <= PH_AHI; is_wr_q <= 1'b0; end
                  OP_WRITE: if (wel_q) begin phase_q <= PH_AHI; is_wr_q <= 1'b1; end
                  OP_WREN:  wel_q <= 1'b1;
                  OP_WRDI:  wel_q <= 1'b0;
                  OP_RDSR:  phase_q <= PH_SRR;
                  OP_WRSR:  if (wel_q && wp_s) phase_q <= PH_SRW;
                  default:  ;
                endcase
              end
            end
            PH_AHI: begin
              addr_q  <= AW'({rx_byte, 8'h00});
              phase_q <= PH_ALO;
            end
            PH_ALO: begin
              addr_q  <= (addr_q & ~AW'(8'hFF)) | AW'(rx_byte);
              phase_q <= is_wr_q ? PH_WDAT : PH_RDAT;
            end
            PH_WDAT: begin
              addr_q      <= {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
              data_seen_q <= 1'b1;
            end
            PH_RDAT: addr_q <= addr_q + 1'b1;
            PH_SRW: begin
              sr_new_q  <= rx_byte[3:2];
              sr_seen_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // SO path: load a fresh byte on the first falling edge of each byte
  logic [7:0] tx_q, tx_src;
  logic       so_q, out_phase;
  assign out_phase = (phase_q == PH_RDAT) || (phase_q == PH_SRR);
  assign tx_src    = (phase_q == PH_RDAT) ? mem_rdata : status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      so_q <= 1'b0;
    end else if (fall && out_phase) begin
      if (bit_cnt_q == 3'd0) begin
        so_q <= tx_src[7];
        tx_q <= {tx_src[6:0], 1'b0};
      end else begin
        so_q <= tx_q[7];
        tx_q <= {tx_q[6:0], 1'b0};
      end
    end
  end

  assign so_o    = so_q;
  assign so_en_o = cs_act & hold_act & out_phase;
endmodule

// File: rtl/eep_chk.sv
module eep_chk
  import eep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_act,
  input logic       hold_act,
  input logic       busy,
  input logic       wel,
  input logic [1:0] bp,
  input logic       mem_we,
  input logic [1:0] wtop,
  input logic [2:0] bit_cnt
);
  // R4
  commit_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> wel);

  // R7
  done_clears_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel);

  // R7
  busy_no_wren_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> !$rose(wel));

  // R8
  locked_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !region_locked(bp, wtop));

  // R10
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && !hold_act) |=> $stable(bit_cnt));

  // R11
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> (bit_cnt == 3'd0));
endmodule

bind spi_eeprom_slave eep_chk i_eep_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_act   (cs_act),
  .hold_act (hold_act),
  .busy     (busy_q),
  .wel      (wel_q),
  .bp       (bp_q),
  .mem_we   (mem_we),
  .wtop     (mem_waddr[AW-1 -: 2]),
  .bit_cnt  (bit_cnt_q)
);

// File: tb/test_spi_eeprom_slave.sv
module test_spi_eeprom_slave;
  localparam int MEM  = 256;
  localparam int PG   = 16;
  localparam int WC   = 300;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_en;

  always #2 clk = ~clk;

  spi_eeprom_slave #(.MEM_BYTES(MEM), .PAGE_BYTES(PG), .WRITE_CYCLES(WC)) i_spi_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .si_i(si), .cs_ni(cs_n),
    .hold_ni(hold_n), .wp_ni(wp_n), .so_o(so), .so_en_o(so_en)
  );

  int total = 0, fails = 0;
  bit done = 1'b0, mode3 = 1'b0, en_any;
  logic [7:0] model [MEM];
  logic [7:0] wbuf [PG];
  logic [7:0] rxb, st;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input bit m); mode3 = m; sck = m; tick(4); endtask
  task automatic cs_lo(); cs_n = 1'b0; tick(HALF); endtask
  task automatic cs_hi(); tick(HALF); cs_n = 1'b1; tick(2*HALF); endtask

  task automatic xfer(input logic [7:0] tx);
    for (int i = 7; i >= 0; i--) begin
      if (mode3) sck = 1'b0;
      si = tx[i];
      tick(HALF);
      rxb[i] = so;
      en_any |= so_en;
      sck = 1'b1;
      tick(HALF);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic op1(input logic [7:0] op); cs_lo(); xfer(op); cs_hi(); endtask
  task automatic rdsr(output logic [7:0] s); cs_lo(); xfer(8'h05); xfer(8'h00); s = rxb; cs_hi(); endtask
  task automatic wrsr(input logic [7:0] v); cs_lo(); xfer(8'h01); xfer(v); cs_hi(); endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  task automatic wr(input int a, input int n);
    cs_lo(); xfer(8'h02); xfer(a[15:8]); xfer(a[7:0]);
    for (int k = 0; k < n; k++) xfer(wbuf[k]);
    cs_hi();
  endtask

  task automatic rd_chk(input int a, input int n, input string tag);
    cs_lo(); xfer(8'h03); xfer(a[15:8]); xfer(a[7:0]);
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = (a + k) & (MEM - 1);
      xfer(8'h00);
      check(rxb === model[idx], tag, rxb, model[idx]);
    end
    cs_hi();
  endtask

  function automatic bit locked(input int bp, input int a);
    int q;
    q = (a & (MEM - 1)) / (MEM / 4);
    case (bp)
      0: return 1'b0;
      1: return q == 3;
      2: return q >= 2;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #600000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check(so_en == 1'b0, "R11 reset so_en", so_en, 0);
    rdsr(st);
    check(st == 8'h00, "R2 reset status", st, 0);

    // fill array page by page, mode 0
    set_mode(1'b0);
    for (int p = 0; p < MEM / PG; p++) begin
      op1(8'h06);
      if (p == 0) begin
        rdsr(st);
        check(st == 8'h02, "R4 wren sets wel", st, 2);
      end
      for (int k = 0; k < PG; k++) begin
        wbuf[k] = 8'((p*PG + k) * 37 + 11);
        model[p*PG + k] = wbuf[k];
      end
      wr(p*PG, PG);
      if (p == 0) begin
        rdsr(st);
        check(st[0] == 1'b1, "R7 wip after commit", st, 1);
      end
      wait_idle();
      if (p == 0) begin
        rdsr(st);
        check(st == 8'h00, "R7 wel cleared at end", st, 0);
      end
    end

    // sequential read with wrap, mode 3
    set_mode(1'b1);
    rd_chk(0, MEM + 2, "R1/R3 mode3 sequential wrap");
    set_mode(1'b0);
    rd_chk(16'h7F05, 4, "R3 upper address ignored");

    // page wrap
    op1(8'h06);
    for (int k = 0; k < 4; k++) begin
      wbuf[k] = 8'h90 + 8'(k);
      model[8'h20 | ((8'hE + k) & 15)] = wbuf[k];
    end
    wr(16'h002E, 4);
    wait_idle();
    rd_chk(16'h0020, 16, "R5 page wrap");

    // write without wel
    wbuf[0] = 8'hA5;
    wr(16'h0050, 1);
    rdsr(st);
    check(st == 8'h00, "R4 no wel no cycle", st, 0);
    rd_chk(16'h0050, 1, "R4 no wel array kept");

    // wrdi
    op1(8'h06);
    op1(8'h04);
    rdsr(st);
    check(st == 8'h00, "R4 wrdi clears wel", st, 0);
    wr(16'h0050, 1);
    rd_chk(16'h0050, 1, "R4 after wrdi array kept");

    // not on byte boundary
    op1(8'h06);
    cs_lo(); xfer(8'h02); xfer(8'h00); xfer(8'h60); xfer(8'h5A);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    end
    cs_hi();
    rdsr(st);
    check(st == 8'h02, "R6 partial byte no commit", st, 2);
    rd_chk(16'h0060, 1, "R6 partial byte array kept");
    cs_lo(); xfer(8'h02); xfer(8'h00); xfer(8'h61); cs_hi();
    rdsr(st);
    check(st == 8'h02, "R6 no data no commit", st, 2);

    // busy ignores everything except rdsr
    wbuf[0] = 8'h3C;
    model[8'h70] = 8'h3C;
    wr(16'h0070, 1);
    op1(8'h06);
    en_any = 1'b0;
    cs_lo(); xfer(8'h03); xfer(8'h00); xfer(8'h70); xfer(8'h00); cs_hi();
    check(en_any == 1'b0, "R7 read ignored while busy", en_any, 0);
    wait_idle();
    rdsr(st);
    check(st == 8'h00, "R7 wren ignored while busy", st, 0);
    rd_chk(16'h0070, 1, "R7 committed byte");

    // block protection sweep
    for (int bp = 0; bp < 4; bp++) begin
      op1(8'h06);
      wrsr(8'(bp << 2));
      wait_idle();
      rdsr(st);
      check(st == 8'(bp << 2), "R2/R8 protect bits", st, bp << 2);
      for (int q = 0; q < 4; q++) begin
        int a;
        a = q * (MEM / 4) + 9 + bp;
        wbuf[0] = 8'hC0 + 8'(bp*4 + q);
        op1(8'h06);
        wr(a, 1);
        if (locked(bp, a)) begin
          rdsr(st);
          check(st == 8'((bp << 2) | 2), "R8 locked no cycle", st, (bp << 2) | 2);
        end else begin
          model[a] = wbuf[0];
          wait_idle();
        end
        rd_chk(a, 1, "R8 protect region");
      end
    end

    // WP blocks status write (protect is 11 now)
    wp_n = 1'b0;
    op1(8'h06);
    wrsr(8'h00);
    rdsr(st);
    check(st == 8'h0E, "R9 wp low blocks wrsr", st, 8'h0E);
    wp_n = 1'b1;
    wrsr(8'h00);
    wait_idle();
    rdsr(st);
    check(st == 8'h00, "R9 wp high allows wrsr", st, 0);

    // hold during a mode 3 read
    set_mode(1'b1);
    cs_lo(); xfer(8'h03); xfer(8'h00); xfer(8'h80);
    xfer(8'h00); check(rxb === model[8'h80], "R10 before hold", rxb, model[8'h80]);
    xfer(8'h00); check(rxb === model[8'h81], "R10 before hold", rxb, model[8'h81]);
    hold_n = 1'b0;
    tick(HALF);
    check(so_en == 1'b0, "R10 so disabled in hold", so_en, 0);
    for (int i = 0; i < 4; i++) begin
      si = i[0]; sck = 1'b0; tick(HALF); sck = 1'b1; tick(HALF);
    end
    hold_n = 1'b1;
    tick(HALF);
    xfer(8'h00); check(rxb === model[8'h82], "R10 resume", rxb, model[8'h82]);
    xfer(8'h00); check(rxb === model[8'h83], "R10 resume", rxb, model[8'h83]);
    cs_hi();

    // CS abort mid byte
    set_mode(1'b0);
    cs_lo(); xfer(8'h03); xfer(8'h00); xfer(8'h10);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    end
    cs_n = 1'b1;
    tick(2*HALF);
    check(so_en == 1'b0, "R11 cs high disables so", so_en, 0);
    rdsr(st);
    check(st == 8'h00, "R11 fresh opcode after abort", st, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule